// File: doc/BRIEF.md
# Two-Way LRU Hit/Miss Tracker

This block keeps the tag and status state of a very small two-way set associative cache. It has four block slots in two sets, and each block holds four bytes. A stream of 10-bit byte addresses arrives one per cycle. Each address is split into a 7-bit tag, a 1-bit set index and a 2-bit byte offset. For each address the block reports a hit or a miss. On a miss it installs the new tag in the addressed set. It fills an empty way first. When the set is full, it overwrites the way used least recently.

The block is used to follow, cycle by cycle, how an access pattern behaves against such a cache. It holds no data, models no backing memory and needs no refill wait, so every lookup completes in one clock. A synchronous clear input empties the whole structure at any time.

Top module: `lru2_tracker`

## Requirements
- R1: After reset the cache holds no valid block. Both `hit` and `miss` are low, and the first access to any block reports a miss.
- R2: For each accepted request, one cycle later `tagOut` equals address bits [9:3], `setOut` equals bit [2] and `offsetOut` equals bits [1:0] of that request.
- R3: A request that is accepted (`reqValid` high, `clear` low) produces exactly one of `hit` or `miss` one cycle later. A cycle without an accepted request leaves both low in the following cycle.
- R4: A request hits when one way of the indexed set is valid and holds the same tag. `way` then reports that way (0 or 1).
- R5: On a miss into a set with an empty way, the empty way is filled. Way 0 is chosen when both ways are empty, and `way` reports the way that was filled.
- R6: On a miss into a set whose two ways are both valid, the least recently used way of that set is overwritten and reported on `way`.
- R7: Each set's recency is refreshed by hits as well as by fills. After an access to way w, the other way is the next to be evicted from that set.
- R8: `clear` invalidates every way and makes each set's next victim way 0. A request in the same cycle as `clear` is dropped, so `hit` and `miss` are low in the next cycle.
- R9: The byte offset does not affect the lookup. Any offset within a resident block hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous invalidate of all ways |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 10 | Byte address of the request |
| hit | output | 1 | Previous request hit |
| miss | output | 1 | Previous request missed |
| way | output | 1 | Way that hit or was filled |
| tagOut | output | 7 | Tag field of the previous request |
| setOut | output | 1 | Set field of the previous request |
| offsetOut | output | 2 | Offset field of the previous request |

## Verification
The outcome of a request (hit or miss, the way, and the decoded fields) is due one cycle after the request is presented. The state it changes applies to a request in the very next cycle. The bench applies each stimulus on a falling edge and computes the expected outcome from a behavioural model of the sets at the same moment. It compares the outputs at the following falling edge, after exactly one rising edge has registered them. Back-to-back requests to the same set therefore exercise the case where a fill must be visible to the very next lookup.

// File: rtl/lru2_pkg.sv
package lru2_pkg;

  // Strobes sent from control to datapath for one lookup cycle
  typedef struct packed {
    logic lookup;  // request accepted this cycle
    logic isHit;   // lookup outcome
    logic fill;    // install tag into `way`
    logic touch;   // hit refresh of recency
    logic way;     // way that hits or is filled
    logic wipe;    // invalidate everything
  } ctrlStrobe_t;

endpackage

// File: rtl/lru2_ctrl.sv
module lru2_ctrl
  import lru2_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        clear,
  input  logic [1:0]  wayValid,
  input  logic [1:0]  wayMatch,
  input  logic        lruBit,
  output ctrlStrobe_t strobe
);

  logic [1:0] hitVec;
  logic       anyHit;
  logic       hitWay;
  logic       victim;

  assign hitVec = wayValid & wayMatch;
  assign anyHit = |hitVec;
  assign hitWay = hitVec[1];

  // Empty ways first (way 0 before way 1), else the recency pointer
  always_comb begin
    if (!wayValid[0])      victim = 1'b0;
    else if (!wayValid[1]) victim = 1'b1;
    else                   victim = lruBit;
  end

  always_comb begin
    strobe        = '0;
    strobe.wipe   = clear;
    strobe.lookup = reqValid && !clear;
    strobe.isHit  = anyHit;
    strobe.fill   = strobe.lookup && !anyHit;
    strobe.touch  = strobe.lookup && anyHit;
    strobe.way    = anyHit ? hitWay : victim;
  end

  // R4
  hit_way_matches_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.touch |-> (wayValid[strobe.way] && wayMatch[strobe.way]));

  // R5
  empty_way0_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fill && !wayValid[0]) |-> (strobe.way == 1'b0));

  // R6
  full_set_lru_victim_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fill && (&wayValid)) |-> (strobe.way == lruBit));

  // R3
  no_double_hit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wayValid[0] && wayValid[1] && wayMatch[0] && wayMatch[1]));

endmodule

// File: rtl/lru2_datapath.sv
module lru2_datapath
  import lru2_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int OFFSET_W = 2,
  parameter int SET_W    = 1,
  localparam int TAG_W   = ADDR_W - SET_W - OFFSET_W,
  localparam int NSETS   = 1 << SET_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  ctrlStrobe_t         strobe,
  output logic [1:0]          wayValid,
  output logic [1:0]          wayMatch,
  output logic                lruBit,
  output logic                hit,
  output logic                miss,
  output logic                way,
  output logic [TAG_W-1:0]    tagOut,
  output logic [SET_W-1:0]    setOut,
  output logic [OFFSET_W-1:0] offsetOut
);

  logic [TAG_W-1:0]    reqTag;
  logic [SET_W-1:0]    reqSet;
  logic [OFFSET_W-1:0] reqOff;

  assign reqTag = reqAddr[ADDR_W-1 -: TAG_W];
  assign reqSet = reqAddr[OFFSET_W +: SET_W];
  assign reqOff = reqAddr[OFFSET_W-1:0];

  logic [NSETS-1:0][1:0]       validArr;
  logic [NSETS-1:0][1:0][TAG_W-1:0] tagArr;
  logic [NSETS-1:0]            lruArr;

  generate
    for (genvar w = 0; w < 2; w++) begin : g_way
      assign wayValid[w] = validArr[reqSet][w];
      assign wayMatch[w] = (tagArr[reqSet][w] == reqTag);
    end
  endgenerate

  assign lruBit = lruArr[reqSet];

  // State arrays
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validArr <= '0;
      tagArr   <= '0;
      lruArr   <= '0;
    end else if (strobe.wipe) begin
      validArr <= '0;
      lruArr   <= '0;
    end else begin
      if (strobe.fill) begin
        validArr[reqSet][strobe.way] <= 1'b1;
        tagArr[reqSet][strobe.way]   <= reqTag;
      end
      if (strobe.fill || strobe.touch) begin
        lruArr[reqSet] <= ~strobe.way;
      end
    end
  end

  // Registered results
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit       <= 1'b0;
      miss      <= 1'b0;
      way       <= 1'b0;
      tagOut    <= '0;
      setOut    <= '0;
      offsetOut <= '0;
    end else begin
      hit  <= strobe.lookup && strobe.isHit;
      miss <= strobe.lookup && !strobe.isHit;
      if (strobe.lookup) begin
        way       <= strobe.way;
        tagOut    <= reqTag;
        setOut    <= reqSet;
        offsetOut <= reqOff;
      end
    end
  end

  // R8
  wipe_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wipe |=> (validArr == '0 && lruArr == '0));

  // R8
  wipe_silences_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wipe |=> (!hit && !miss));

  // R7
  lru_flips_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fill || strobe.touch) |=> (lruArr[$past(reqSet)] != $past(strobe.way)));

  // R5
  fill_installs_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |=> (validArr[$past(reqSet)][$past(strobe.way)] &&
                     tagArr[$past(reqSet)][$past(strobe.way)] == $past(reqTag)));

  // R2
  fields_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lookup |=> (tagOut == $past(reqTag) && setOut == $past(reqSet) &&
                       offsetOut == $past(reqOff)));

endmodule

// File: rtl/lru2_tracker.sv
module lru2_tracker
  import lru2_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int OFFSET_W = 2,
  parameter int SET_W    = 1,
  localparam int TAG_W   = ADDR_W - SET_W - OFFSET_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                clear,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  output logic                hit,
  output logic                miss,
  output logic                way,
  output logic [TAG_W-1:0]    tagOut,
  output logic [SET_W-1:0]    setOut,
  output logic [OFFSET_W-1:0] offsetOut
);

  ctrlStrobe_t strobe;
  logic [1:0]  wayValid;
  logic [1:0]  wayMatch;
  logic        lruBit;

  lru2_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .clear    (clear),
    .wayValid (wayValid),
    .wayMatch (wayMatch),
    .lruBit   (lruBit),
    .strobe   (strobe)
  );

  lru2_datapath #(
    .ADDR_W   (ADDR_W),
    .OFFSET_W (OFFSET_W),
    .SET_W    (SET_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .reqAddr   (reqAddr),
    .strobe    (strobe),
    .wayValid  (wayValid),
    .wayMatch  (wayMatch),
    .lruBit    (lruBit),
    .hit       (hit),
    .miss      (miss),
    .way       (way),
    .tagOut    (tagOut),
    .setOut    (setOut),
    .offsetOut (offsetOut)
  );

  // R3
  one_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !clear) |=> (hit != miss));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && !clear) |=> (!hit && !miss));

endmodule

// File: tb/lru2_tracker_bench.sv
module lru2_tracker_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       clear = 1'b0;
  logic       reqValid = 1'b0;
  logic [9:0] reqAddr = '0;
  logic       hit, miss, way;
  logic [6:0] tagOut;
  logic [0:0] setOut;
  logic [1:0] offsetOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  lru2_tracker u_lru2_tracker (
    .clk(clk), .rstN(rstN), .clear(clear), .reqValid(reqValid),
    .reqAddr(reqAddr), .hit(hit), .miss(miss), .way(way),
    .tagOut(tagOut), .setOut(setOut), .offsetOut(offsetOut)
  );

  int compared = 0;
  int mismatched = 0;

  // Behavioural model of the two sets
  int mValid[2][2];
  int mTag[2][2];
  int mLru[2];

  // Pending expectation for the next falling edge
  bit    pend = 0;
  bit    eReq;
  bit    eHit, eMiss, eWay;
  int    eTag, eSet, eOff;
  string eLbl;

  function automatic logic [9:0] mk(int t, int s, int o);
    logic [6:0] tt = t[6:0];
    return {tt, s[0], o[1:0]};
  endfunction

  task automatic modelClear();
    for (int s = 0; s < 2; s++) begin
      mLru[s] = 0;
      for (int w = 0; w < 2; w++) begin mValid[s][w] = 0; mTag[s][w] = 0; end
    end
  endtask

  task automatic checkPending();
    if (!pend) return;
    compared++;
    if (hit !== eHit || miss !== eMiss) begin
      mismatched++;
      $display("FAIL %s hit/miss got %b/%b expected %b/%b", eLbl, hit, miss, eHit, eMiss);
    end
    if (eReq) begin
      compared++;
      if (way !== eWay) begin
        mismatched++;
        $display("FAIL %s way got %0d expected %0d", eLbl, way, eWay);
      end
      compared++;
      if (tagOut !== eTag[6:0] || setOut !== eSet[0:0] || offsetOut !== eOff[1:0]) begin
        mismatched++;
        $display("FAIL R2 fields got %0d/%0d/%0d expected %0d/%0d/%0d",
                 tagOut, setOut, offsetOut, eTag, eSet, eOff);
      end
    end
  endtask

  task automatic step(input bit v, input logic [9:0] a, input bit c, input string extra);
    int t, s, hw;
    @(negedge clk);
    checkPending();
    reqValid = v;
    reqAddr  = a;
    clear    = c;
    pend = 1;
    eHit = 0; eMiss = 0; eWay = 0; eReq = 0;
    t = int'(a[9:3]); s = int'(a[2]);
    eTag = t; eSet = s; eOff = int'(a[1:0]);
    if (c) begin
      modelClear();
      eLbl = {"R8 ", extra};
    end else if (!v) begin
      eLbl = {"R3 ", extra};
    end else begin
      eReq = 1;
      hw = -1;
      for (int w = 0; w < 2; w++)
        if (mValid[s][w] != 0 && mTag[s][w] == t) hw = w;
      if (hw >= 0) begin
        eHit = 1; eWay = hw[0];
        mLru[s] = 1 - hw;
        eLbl = {"R4 ", extra};
      end else begin
        eMiss = 1;
        if (mValid[s][0] == 0)      begin hw = 0; eLbl = {"R5 ", extra}; end
        else if (mValid[s][1] == 0) begin hw = 1; eLbl = {"R5 ", extra}; end
        else                        begin hw = mLru[s]; eLbl = {"R6 ", extra}; end
        eWay = hw[0];
        mValid[s][hw] = 1;
        mTag[s][hw] = t;
        mLru[s] = 1 - hw;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    compared++;
    if (hit !== 1'b0 || miss !== 1'b0) begin
      mismatched++;
      $display("FAIL R1 reset got %b/%b expected 0/0", hit, miss);
    end
    // R1 empty cache misses
    step(1, mk(5, 0, 0), 0, "R1");
    step(1, mk(5, 1, 2), 0, "R1");
    // R9 other offsets of resident blocks hit
    step(1, mk(5, 0, 3), 0, "R9");
    step(1, mk(5, 1, 1), 0, "R9");
    // R5 second empty way
    step(1, mk(6, 0, 0), 0, "R5");
    // R7 a hit refreshes recency
    step(1, mk(5, 0, 1), 0, "R7");
    step(1, mk(7, 0, 0), 0, "R7");
    step(1, mk(5, 0, 2), 0, "R7");
    step(1, mk(6, 0, 0), 0, "R6");
    step(0, mk(6, 0, 0), 0, "R3");
    // R8 clear with a request in the same cycle
    step(1, mk(5, 0, 0), 1, "R8");
    step(1, mk(5, 0, 0), 0, "R8");
    step(1, mk(9, 0, 0), 0, "R8");
    // Mixed stream
    void'($urandom(11));
    for (int n = 0; n < 4000; n++) begin
      int r  = int'($urandom % 64);
      int tg = int'($urandom % 4);
      int st = int'($urandom % 2);
      int of = int'($urandom % 4);
      step(r < 48, mk(tg, st, of), r == 63, "mix");
    end
    step(0, '0, 0, "R3");
    @(negedge clk);
    checkPending();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule